// File: doc/BRIEF.md
# Queued Serial Transfer Pointer Sequencer

This block walks the 16-entry command/data queue of a queued serial peripheral. It drives the queue index of the transfer now in progress. An external serializer reports each finished transfer with a one-cycle done strobe, and the block then advances the index. Software programs a first and a last entry. It can also make the queue run forever by wrapping, either back to entry 0 or back to the first entry. A halt request parks the sequencer at the next transfer boundary. When the last entry completes, a sticky finished flag is set, and that flag can raise an interrupt.

Control settings written while the queue is running are held in a pending copy. That copy replaces the active settings at the next transfer boundary. If the pending first-entry value differs from the active one, the sequence restarts at the new entry instead of stepping forward. A read of the control register always shows the active copy. The status register shows the index of the last completed entry, the finished flag, the halt request and the halt acknowledge.

Top module: `qptr_seq`

## Requirements
- R1: A rising edge on `run_en` while the sequencer is idle makes `busy` high and loads `cur_ptr` with the active first entry on the same clock edge.
- R2: While the sequencer is running and not halted, a `xfer_done` pulse on an entry that is not the last entry moves `cur_ptr` to the next entry, modulo 16. A last entry numerically below the first entry is therefore reached by rolling over from 15 to 0.
- R3: The control register has these fields: first entry in bits 3:0, last entry in bits 7:4, wrap enable in bit 8, wrap target in bit 9 (0 means entry 0, 1 means the first entry) and finished interrupt enable in bit 10. A control write takes effect at once when the sequencer is idle. A control write made while it is running is held pending and becomes active on the next accepted done pulse. Until then, reads return the old active value.
- R4: If a pending first-entry value differs from the active one when a done pulse is accepted, `cur_ptr` moves to the new first entry instead of advancing.
- R5: With wrap disabled, a done pulse on the last entry leaves `cur_ptr` on that entry, drops `busy` and sets the finished flag. Later done pulses change neither `cur_ptr` nor the completed-entry field.
- R6: With wrap enabled, a done pulse on the last entry sets the finished flag, keeps `busy` high and moves `cur_ptr` to entry 0 or to the first entry, as selected by the wrap target bit.
- R7: The finished flag is status bit 4. It stays set until software writes a status word with bit 4 at 0. Writing 1 to that bit leaves it unchanged.
- R8: `irq` is high exactly when the finished flag is set and the active finished interrupt enable bit is 1.
- R9: Status bits 3:0 hold the index of the entry whose done pulse was most recently accepted.
- R10: Status bit 5 is a halt request. When a done pulse is accepted while the request is set, the sequencer advances as usual and then sets the halt acknowledge in status bit 6. While the acknowledge is set, done pulses are ignored. Clearing the request clears the acknowledge, and the sequencer continues from the entry it parked on.
- R11: With `run_en` low, `busy` goes low on the next clock edge and done pulses are ignored.
- R12: After reset, `cur_ptr`, `busy`, `irq` and both register read values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select for reads and writes: 0 control, 1 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register (active control value or status) |
| run_en | input | 1 | Enable; its rising edge starts the queue |
| xfer_done | input | 1 | One-cycle pulse from the serializer at the end of a transfer |
| cur_ptr | output | 4 | Queue index of the current transfer |
| busy | output | 1 | Sequencer is running |
| irq | output | 1 | Finished interrupt |

## Verification
The hardest situation to reach from the ports is a transfer boundary where a pending control word and the active one meet. The pending word is only seen once it becomes active, so the stimulus reads the control register before and after the done pulse to show the handover. The bench rewrites the first entry while an entry other than the last is in flight and confirms that the index jumps there rather than stepping. It also shows that a pending interrupt enable turns on `irq` for a finished flag that was already set. A halted state is reached by setting the halt request mid-run. The bench then confirms that a done pulse leaves both the index and the completed field untouched until the request is cleared.

// File: rtl/qptr_pkg.sv
package qptr_pkg;
  parameter int unsigned QP_W  = 4;
  parameter int unsigned REG_W = 16;

  typedef logic [QP_W-1:0] qp_t;

  // active / pending control word; first entry sits in the low bits
  typedef struct packed {
    logic fin_ie;
    logic wrap_to_first;
    logic wrap_on;
    qp_t  last;
    qp_t  first;
  } qctl_t;

  localparam int unsigned CTL_W   = $bits(qctl_t);
  localparam int unsigned ST_FIN  = QP_W;
  localparam int unsigned ST_HALT = QP_W + 1;
  localparam int unsigned ST_ACK  = QP_W + 2;
  localparam int unsigned ST_W    = QP_W + 3;
endpackage

// File: rtl/qptr_shadow.sv
module qptr_shadow
  import qptr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_wr,
  input  qctl_t ctl_wdata,
  input  logic  busy,
  input  logic  done_ev,
  output qctl_t act,
  output logic  restart,
  output qp_t   restart_ptr
);
  qctl_t pend, pend_n, act_n;
  logic  pend_v, pend_v_n;
  logic  apply;
  logic  act_en, pend_en;

  assign apply = pend_v & (done_ev | ~busy);

  always_comb begin
    act_n    = act;
    pend_n   = pend;
    pend_v_n = pend_v;
    if (apply) begin
      act_n    = pend;
      pend_v_n = 1'b0;
    end
    if (ctl_wr) begin
      if (busy) begin
        pend_n   = ctl_wdata;
        pend_v_n = 1'b1;
      end else begin
        act_n    = ctl_wdata;
        pend_v_n = 1'b0;
      end
    end
  end

  assign act_en  = apply | (ctl_wr & ~busy);
  assign pend_en = ctl_wr & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
    end else begin
      if (act_en)  act  <= act_n;
      if (pend_en) pend <= pend_n;
      pend_v <= pend_v_n;
    end
  end

  assign restart     = pend_v & done_ev & (pend.first != act.first);
  assign restart_ptr = pend.first;

  AST_PEND_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctl_wr && !done_ev |=> act == $past(act)); // R3
  AST_PEND_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev && pend_v |=> act == $past(pend)); // R3
endmodule

// File: rtl/qptr_stepper.sv
module qptr_stepper
  import qptr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_en,
  input  logic  xfer_done,
  input  logic  halt_ack,
  input  qctl_t act,
  input  logic  restart,
  input  qp_t   restart_ptr,
  output qp_t   cur,
  output logic  busy,
  output logic  done_ev,
  output logic  fin_ev
);
  logic run_q;
  logic start_ev, at_end;
  logic busy_n;
  qp_t  cur_n, wrap_tgt;
  logic cur_en;

  assign start_ev = run_en & ~run_q & ~busy;
  assign done_ev  = xfer_done & busy & run_en & ~halt_ack;
  assign at_end   = (cur == act.last);
  assign fin_ev   = done_ev & at_end;
  assign wrap_tgt = act.wrap_to_first ? act.first : '0;

  always_comb begin
    busy_n = busy;
    cur_n  = cur;
    if (busy && !run_en) begin
      busy_n = 1'b0;
    end else if (start_ev) begin
      busy_n = 1'b1;
      cur_n  = act.first;
    end else if (done_ev) begin
      if (restart) begin
        cur_n = restart_ptr;
      end else if (at_end) begin
        if (act.wrap_on) cur_n  = wrap_tgt;
        else             busy_n = 1'b0;
      end else begin
        cur_n = cur + 1'b1;
      end
    end
  end

  assign cur_en = start_ev | done_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      busy  <= 1'b0;
      cur   <= '0;
    end else begin
      run_q <= run_en;
      busy  <= busy_n;
      if (cur_en) cur <= cur_n;
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && run_en && !run_q |=> busy && cur == $past(act.first)); // R1
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev && !restart && !at_end |=> cur == qp_t'($past(cur) + 1'b1)); // R2
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(run_en && !run_q) |=> $stable(cur)); // R5
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !busy); // R11
endmodule

// File: rtl/qptr_status.sv
module qptr_status
  import qptr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic st_wr,
  input  logic wr_fin,
  input  logic wr_halt,
  input  logic done_ev,
  input  logic fin_ev,
  input  qp_t  cur,
  output qp_t  comp,
  output logic fin,
  output logic halt_req,
  output logic halt_ack
);
  logic fin_n, halt_req_n, halt_ack_n;

  always_comb begin
    fin_n = fin;
    if (st_wr && !wr_fin) fin_n = 1'b0;
    if (fin_ev)           fin_n = 1'b1;
    halt_req_n = st_wr ? wr_halt : halt_req;
    halt_ack_n = halt_req_n & (halt_ack | (done_ev & halt_req));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp     <= '0;
      fin      <= 1'b0;
      halt_req <= 1'b0;
      halt_ack <= 1'b0;
    end else begin
      if (done_ev) comp <= cur;
      fin      <= fin_n;
      halt_req <= halt_req_n;
      halt_ack <= halt_ack_n;
    end
  end

  AST_FIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !(st_wr && !wr_fin) |=> fin); // R7
  AST_COMP_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> comp == $past(cur)); // R9
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ack |-> halt_req); // R10
endmodule

// File: rtl/qptr_seq.sv
module qptr_seq
  import qptr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             run_en,
  input  logic             xfer_done,
  output logic [QP_W-1:0]  cur_ptr,
  output logic             busy,
  output logic             irq
);
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  qctl_t act;
  logic  restart, done_ev, fin_ev;
  qp_t   restart_ptr, cur, comp;
  logic  fin, halt_req, halt_ack;
  logic  ctl_wr, st_wr;
  logic  unused_wdata;

  assign ctl_wr       = reg_wr & ~reg_sel;
  assign st_wr        = reg_wr & reg_sel;
  assign unused_wdata = ^reg_wdata[REG_W-1:CTL_W];

  qptr_shadow u_shadow (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (qctl_t'(reg_wdata[CTL_W-1:0])),
    .busy        (busy),
    .done_ev     (done_ev),
    .act         (act),
    .restart     (restart),
    .restart_ptr (restart_ptr)
  );

  qptr_stepper u_stepper (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .run_en      (run_en),
    .xfer_done   (xfer_done),
    .halt_ack    (halt_ack),
    .act         (act),
    .restart     (restart),
    .restart_ptr (restart_ptr),
    .cur         (cur),
    .busy        (busy),
    .done_ev     (done_ev),
    .fin_ev      (fin_ev)
  );

  qptr_status u_status (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .st_wr    (st_wr),
    .wr_fin   (reg_wdata[ST_FIN]),
    .wr_halt  (reg_wdata[ST_HALT]),
    .done_ev  (done_ev),
    .fin_ev   (fin_ev),
    .cur      (cur),
    .comp     (comp),
    .fin      (fin),
    .halt_req (halt_req),
    .halt_ack (halt_ack)
  );

  logic [ST_W-1:0] st_word;
  assign st_word   = {halt_ack, halt_req, fin, comp};
  assign reg_rdata = reg_sel ? REG_W'(st_word) : REG_W'(act);
  assign cur_ptr   = cur;
  assign irq       = fin & act.fin_ie;

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_s_n)
    halt_ack && busy && run_en |=> $stable(cur_ptr)); // R10
  AST_FIN_AT_LAST: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(fin) |-> $past(cur) == $past(act.last)); // R5
endmodule

// File: tb/qptr_seq_test.sv
`timescale 1ns/100ps
module qptr_seq_test;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        run_en;
  logic        xfer_done;
  logic [3:0]  cur_ptr;
  logic        busy;
  logic        irq;

  qptr_seq uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .run_en    (run_en),
    .xfer_done (xfer_done),
    .cur_ptr   (cur_ptr),
    .busy      (busy),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    string rq;
    int    what;
    int    exp;
  } item_t;

  item_t q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      #0.1;
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.what)
          0:       act = int'(cur_ptr);
          1:       act = int'(busy);
          2:       act = int'(irq);
          default: act = int'(reg_rdata);
        endcase
        n_chk++;
        if (act != it.exp) begin
          n_fail++;
          $display("FAIL %s: what=%0d actual=0x%0h expected=0x%0h", it.rq, it.what, act, it.exp);
        end
      end
    end
  end

  task automatic push(string rq, int what, int exp);
    item_t it;
    it.rq = rq; it.what = what; it.exp = exp;
    q.push_back(it);
    #0.2;
  endtask

  task automatic rd(string rq, logic s, int exp);
    reg_sel = s;
    push(rq, 3, exp);
  endtask

  task automatic wr(logic s, logic [15:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_done();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic set_run(logic v);
    run_en = v;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!ended) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    run_en = 1'b0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    push("R12", 0, 0);
    push("R12", 1, 0);
    push("R12", 2, 0);
    rd("R12", 1'b0, 0);
    rd("R12", 1'b1, 0);

    // R3 idle write is immediate: first=3 last=6 no wrap, irq enabled
    wr(1'b0, 16'h0463);
    rd("R3", 1'b0, 16'h0463);

    // R1 start
    set_run(1'b1);
    push("R1", 0, 3);
    push("R1", 1, 1);

    // R2 / R9 stepping
    pulse_done();
    push("R2", 0, 4);
    rd("R9", 1'b1, 3);
    pulse_done();
    pulse_done();
    push("R2", 0, 6);

    // R5 / R8 end without wrap
    pulse_done();
    push("R5", 0, 6);
    push("R5", 1, 0);
    push("R8", 2, 1);
    rd("R5", 1'b1, 16'h0016);
    pulse_done();
    push("R5", 0, 6);
    rd("R5", 1'b1, 16'h0016);

    // R7 write 1 keeps flag, write 0 clears
    wr(1'b1, 16'h0010);
    rd("R7", 1'b1, 16'h0016);
    wr(1'b1, 16'h0000);
    rd("R7", 1'b1, 16'h0006);
    push("R8", 2, 0);

    // R2 rollover: first=14 last=1 wrap to entry 0, irq disabled
    set_run(1'b0);
    wr(1'b0, 16'h011E);
    set_run(1'b1);
    push("R1", 0, 14);
    pulse_done();
    push("R2", 0, 15);
    pulse_done();
    push("R2", 0, 0);
    pulse_done();
    push("R2", 0, 1);
    pulse_done();
    push("R6", 0, 0);
    push("R6", 1, 1);
    push("R8", 2, 0);

    // R3 pending write while running: wrap to first, irq enabled
    wr(1'b0, 16'h071E);
    rd("R3", 1'b0, 16'h011E);
    push("R8", 2, 0);
    pulse_done();
    push("R3", 0, 1);
    rd("R3", 1'b0, 16'h071E);
    push("R8", 2, 1);
    wr(1'b1, 16'h0000);
    push("R8", 2, 0);
    pulse_done();
    push("R6", 0, 14);
    push("R8", 2, 1);

    // R4 restart at new first entry
    wr(1'b0, 16'h0715);
    pulse_done();
    push("R4", 0, 5);
    rd("R4", 1'b0, 16'h0715);

    // R10 halt
    wr(1'b1, 16'h0020);
    pulse_done();
    push("R10", 0, 6);
    rd("R10", 1'b1, 16'h0065);
    pulse_done();
    push("R10", 0, 6);
    rd("R10", 1'b1, 16'h0065);
    wr(1'b1, 16'h0000);
    rd("R10", 1'b1, 16'h0005);
    pulse_done();
    push("R10", 0, 7);
    rd("R10", 1'b1, 16'h0006);

    // R11 stop
    set_run(1'b0);
    push("R11", 1, 0);
    pulse_done();
    push("R11", 0, 7);
    rd("R11", 1'b1, 16'h0006);

    repeat (2) @(negedge clk);
    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule